// File: doc/BRIEF.md
# SD/MMC Command Token Transmitter

This block builds the 48-bit command token that an SD or MMC host sends on the CMD line, and shifts it out serially. A host loads the command index and the 32-bit argument through three 16-bit write registers. A one-cycle start strobe makes the block capture those fields and frame them. The frame gets a leading `01` pair. The block then computes a CRC7 over the first 40 bits and appends it with a closing `1`. The token leaves most significant bit first, and the line moves forward by one bit on each cycle in which the card-clock enable input is high.

While it shifts, the block drives the line and raises its output enable. At all other times it releases the line, and the reported level is the idle-high level of the pull-up. When the last bit has been consumed, a single-cycle done pulse marks the end of the frame. The block always computes the CRC itself, so the CRC byte position in the low register is write-ignored. Clock generation, response capture and the data lines sit outside this block.

Top module: `sdcmd_token_tx`

## Requirements
- R1: After reset, `cmd_oe`=0, `cmd_out`=1, `done`=0 and `busy`=0.
- R2: Bits 47..40 on the wire are `0`, `1`, then the 6-bit command index MSB first, so the first byte equals 0x40 | index.
- R3: Bits 39..8 on the wire are the 32-bit argument, most significant bit first.
- R4: Bits 7..1 on the wire are the CRC7 of bits 47..8 (generator x^7+x^3+1, zero initial value, MSB first), and bit 0 is a constant 1. Example: index 0 with argument 0 gives a last byte of 0x95; index 8 with argument 0x1AA gives 0x87.
- R5: Register packing: `wr_sel`=2 loads index from `wr_data[13:8]` and argument[31:24] from `wr_data[7:0]`, and `wr_data[15:14]` is ignored. `wr_sel`=1 loads argument[23:8]. `wr_sel`=0 loads argument[7:0] from `wr_data[15:8]`, and `wr_data[7:0]` is ignored, because the CRC is always recomputed. `wr_sel`=3 is ignored.
- R6: The line advances by exactly one bit per cycle with `clk_en` high while busy. Without `clk_en`, `cmd_out` holds its value.
- R7: `cmd_oe` is 1 from the cycle after an accepted start until the 48th bit is consumed, and 0 otherwise. While `cmd_oe` is 0, `cmd_out` is 1.
- R8: In the cycle after the 48th `clk_en`, `done` is 1 for exactly one cycle, and `busy` and `cmd_oe` are 0 in that same cycle.
- R9: A `start` that arrives while busy is ignored. This includes a start in the same cycle as the 48th `clk_en`, which starts no new frame.
- R10: The token is captured at the accepted start. Register writes made during a frame do not change the bits of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (2 top, 1 middle, 0 low) |
| wr_data | input | 16 | Register write data |
| start | input | 1 | One-cycle request to send the loaded token |
| clk_en | input | 1 | One-cycle card-clock enable; each one consumes one bit |
| cmd_out | output | 1 | Serial command bit |
| cmd_oe | output | 1 | Output enable for the CMD line |
| done | output | 1 | One-cycle pulse after the last bit |
| busy | output | 1 | A frame is in progress |

## Verification
Two pairs of events can fall in the same cycle. The first is a new start request and the clock enable that consumes the final bit. The bench raises `start` together with the 48th `clk_en`, then requires the done pulse and a line that stays released, with no second frame. The second is a register write and a running frame. The bench rewrites the middle register and raises `start` halfway through a frame, then compares the full 48 captured bits against the token it computed by polynomial division from the fields loaded before the start.

// File: rtl/sdcmd_token_tx.sv
module sdcmd_token_tx #(
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int CRC_W    = 7,
  parameter logic [6:0] CRC_POLY = 7'h09
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic        start,
  input  logic        clk_en,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        done,
  output logic        busy
);
  localparam int HEAD_W = 2 + IDX_W + ARG_W;
  localparam int TOK_W  = HEAD_W + CRC_W + 1;
  localparam int CNT_W  = $clog2(TOK_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOK_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [ARG_W-1:0]  arg_q;
  logic [TOK_W-1:0]  sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;
  logic [HEAD_W-1:0] head;

  function automatic logic [CRC_W-1:0] crc_of(input logic [HEAD_W-1:0] m);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) begin
      fb = m[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY[CRC_W-1:0];
    end
    return c;
  endfunction

  assign head = {2'b01, idx_q, arg_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      arg_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd2: begin
          idx_q        <= wr_data[13:8];
          arg_q[31:24] <= wr_data[7:0];
        end
        2'd1: arg_q[23:8] <= wr_data;
        2'd0: arg_q[7:0]  <= wr_data[15:8];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          sh_q   <= {head, crc_of(head), 1'b1};
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else if (clk_en) begin
        sh_q  <= {sh_q[TOK_W-2:0], 1'b1};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cmd_out = busy_q ? sh_q[TOK_W-1] : 1'b1;
  assign cmd_oe  = busy_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/sdcmd_token_tx_chk.sv
module sdcmd_token_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic clk_en,
  input logic cmd_out,
  input logic cmd_oe,
  input logic done,
  input logic busy
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_oe && !busy));
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clk_en) |=> (busy && $stable(cmd_out)));
  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !clk_en) |=> (busy && $stable(cmd_out)));
endmodule

bind sdcmd_token_tx sdcmd_token_tx_chk u_chk (.*);

// File: tb/sim_sdcmd_token_tx.sv
module sim_sdcmd_token_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic start = 1'b0;
  logic clk_en = 1'b0;
  logic cmd_out, cmd_oe, done, busy;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sdcmd_token_tx u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_frame(input logic [5:0] idx, input logic [31:0] arg, input int gap, input bit poke);
    logic [47:0] got, exp;
    bit oe_ok, hold_ok;
    logic held;
    wr(2'd2, {2'b10, idx, arg[31:24]});
    wr(2'd1, arg[23:8]);
    wr(2'd0, {arg[7:0], 8'h5A ^ {2'b0, idx}});
    wr(2'd3, 16'hFFFF);
    exp = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    oe_ok = 1'b1; hold_ok = 1'b1;
    for (int b = 0; b < 48; b++) begin
      held = cmd_out;
      for (int w = 0; w < gap; w++) begin
        @(negedge clk);
        if (cmd_out !== held || cmd_oe !== 1'b1) hold_ok = 1'b0;
      end
      got[47-b] = cmd_out;
      if (cmd_oe !== 1'b1 || done !== 1'b0) oe_ok = 1'b0;
      clk_en = 1'b1;
      if (poke && b == 20) begin
        start = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = ~arg[23:8];
      end
      if (poke && b == 47) start = 1'b1;
      @(negedge clk);
      clk_en = 1'b0; start = 1'b0; wr_en = 1'b0;
    end
    chk(got[47:40] === (8'h40 | {2'b0, idx}), "R2 first byte", got[47:40], 8'h40 | {2'b0, idx});
    chk(got[39:8] === arg, "R3 argument", got[39:8], arg);
    chk(got[7:0] === exp[7:0], "R4 R5 crc byte", got[7:0], exp[7:0]);
    if (poke) chk(got === exp, "R10 R9 frame intact", got, exp);
    chk(oe_ok, "R7 oe during frame", oe_ok, 1);
    if (gap > 0) chk(hold_ok, "R6 hold without clk_en", hold_ok, 1);
    chk(done === 1'b1 && cmd_oe === 1'b0 && busy === 1'b0 && cmd_out === 1'b1,
        "R8 done after last bit", {done, cmd_oe, busy, cmd_out}, 4'b1001);
    @(negedge clk);
    chk(done === 1'b0 && cmd_oe === 1'b0, "R8 R9 single done, no restart", {done, cmd_oe}, 2'b00);
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [47:0] tok;
    repeat (3) @(negedge clk);
    chk(cmd_oe === 1'b0 && cmd_out === 1'b1 && done === 1'b0 && busy === 1'b0,
        "R1 reset state", {cmd_oe, cmd_out, done, busy}, 4'b0100);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b0; clk_en = 1'b1;
    repeat (3) @(negedge clk);
    clk_en = 1'b0;
    chk(cmd_oe === 1'b0 && cmd_out === 1'b1, "R7 R6 idle ignores clk_en", {cmd_oe, cmd_out}, 2'b01);
    tok = {2'b01, 6'd0, 32'd0, ref_crc({2'b01, 6'd0, 32'd0}), 1'b1};
    chk(tok[7:0] === 8'h95, "R4 known vector idx0", tok[7:0], 8'h95);
    tok = {2'b01, 6'd8, 32'h1AA, ref_crc({2'b01, 6'd8, 32'h1AA}), 1'b1};
    chk(tok[7:0] === 8'h87, "R4 known vector idx8", tok[7:0], 8'h87);
    run_frame(6'd0, 32'h0, 0, 1'b0);
    run_frame(6'd8, 32'h1AA, 1, 1'b0);
    for (int i = 0; i < 64; i++)
      run_frame(i[5:0], {i[7:0], 8'hC3 ^ i[7:0], i[7:0] * 8'd37, ~i[7:0]}, i % 3, 1'b0);
    run_frame(6'h3F, 32'hFFFF_FFFF, 0, 1'b0);
    run_frame(6'h2A, 32'h8000_0001, 2, 1'b1);
    run_frame(6'h11, 32'h1234_5678, 0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule